// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI/LO Result Pair

This block performs integer multiplication and division on two operands one bit per cycle and keeps the outcome in a private pair of result registers, HI and LO. A product is twice the operand width, split across the pair. A division leaves its quotient in LO and its remainder in HI. The result pair is never driven onto the block's outputs directly. A separate move operation reads one half of it through a registered read port, and the value is then written to a general register.

A core issues an operation by pulsing the start input with an operation code and two operands. The unit raises its busy flag for a fixed number of cycles, one setup cycle followed by one iteration per operand bit. The core stalls on that flag: it holds any move operation until busy has fallen. Signed operations turn both operands into magnitudes, run the same unsigned engine, and correct the signs of the results on the way into HI/LO.

Top module: `mdu_unit`

## Requirements
- R1: Operation code 1 (unsigned multiply) writes the full unsigned product of the two operands, upper half into HI and lower half into LO.
- R2: Operation code 0 (signed multiply) treats both operands as two's complement values and writes their full two's complement product into HI (upper) and LO (lower).
- R3: Operation code 3 (unsigned divide) writes the quotient into LO and the remainder into HI. The remainder is always less than the divisor.
- R4: Operation code 2 (signed divide) writes into LO a quotient truncated toward zero. When neither operand is negative, the remainder in HI is exact. For negative operands, HI is not specified.
- R5: After an arithmetic start is accepted, busy is high for exactly WIDTH+1 cycles, and then falls with the new HI/LO already in place.
- R6: A start pulse while busy is high has no effect. It gives no read pulse and does not alter the running operation or its result.
- R7: Operation code 4 reads HI and code 5 reads LO. One cycle after the start is accepted, the read valid flag is high for one cycle with the selected value on the read data output. Reads leave HI and LO unchanged.
- R8: After reset, busy and read valid are low and both HI and LO read as zero.
- R9: A divide by a zero divisor raises no error. It completes in the same WIDTH+1 busy cycles, and the values it leaves in HI/LO are not specified.
- R10: Operation codes 6 and 7 are ignored. They raise no busy, give no read pulse, and leave HI/LO unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Issue pulse for one operation |
| op_i | input | 3 | Operation code (0 mult, 1 multu, 2 div, 3 divu, 4 read HI, 5 read LO) |
| opa_i | input | WIDTH | First operand (multiplicand / dividend) |
| opb_i | input | WIDTH | Second operand (multiplier / divisor) |
| busy_o | output | 1 | High while an arithmetic operation runs |
| rd_valid_o | output | 1 | One-cycle pulse marking read data valid |
| rd_data_o | output | WIDTH | HI or LO value returned by a read |

## Verification
Nearly all state is hidden behind HI/LO, so an internal fault becomes visible only when a move operation reads the pair back. That happens one cycle after the first read following completion. A wrong iteration count or control state shows up earlier, as a busy length other than WIDTH+1 on that same operation. A corrupted sign correction affects only operand patterns with negative inputs. For that reason, the vectors mix signs, extreme values and the most negative number. A fault in the busy gating shows as a read pulse, or as a changed result, after a start issued in the middle of an operation.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

   typedef enum logic [2:0] {
      MDU_MULT  = 3'd0,
      MDU_MULTU = 3'd1,
      MDU_DIV   = 3'd2,
      MDU_DIVU  = 3'd3,
      MDU_RDHI  = 3'd4,
      MDU_RDLO  = 3'd5,
      MDU_RSV6  = 3'd6,
      MDU_RSV7  = 3'd7
   } mdu_op_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SETUP = 2'd1,
      ST_ITER  = 2'd2
   } mdu_state_e;

   function automatic logic op_is_arith(mdu_op_e o);
      return (o == MDU_MULT) || (o == MDU_MULTU) || (o == MDU_DIV) || (o == MDU_DIVU);
   endfunction

   function automatic logic op_is_read(mdu_op_e o);
      return (o == MDU_RDHI) || (o == MDU_RDLO);
   endfunction

   function automatic logic op_is_div(mdu_op_e o);
      return (o == MDU_DIV) || (o == MDU_DIVU);
   endfunction

   function automatic logic op_is_signed(mdu_op_e o);
      return (o == MDU_MULT) || (o == MDU_DIV);
   endfunction

endpackage

// File: rtl/mdu_sign_prep.sv
module mdu_sign_prep #(
   parameter int W = 32
) (
   input  logic         signed_en_i,
   input  logic [W-1:0] opnd_i,
   output logic [W-1:0] mag_o,
   output logic         neg_o
);

   always_comb begin
      neg_o = signed_en_i & opnd_i[W-1];
      mag_o = neg_o ? (~opnd_i + W'(1)) : opnd_i;
   end

endmodule

// File: rtl/mdu_iter_core.sv
module mdu_iter_core #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic         step_i,
   input  logic         div_i,
   input  logic [W-1:0] mag_a_i,
   input  logic [W-1:0] mag_b_i,
   output logic [W-1:0] nxt_hi_o,
   output logic [W-1:0] nxt_lo_o
);

   logic [W-1:0] hi_q, lo_q, b_q;

   // shift-add multiply step: accumulate, then shift {acc, multiplier} right
   logic [W:0]   mul_sum;
   logic [W-1:0] mul_hi, mul_lo;
   // restoring divide step: shift left, trial subtract, keep or restore
   logic [W:0]   div_shift;
   logic         div_ge;
   logic [W-1:0] div_hi, div_lo;

   always_comb begin
      mul_sum   = {1'b0, hi_q} + (lo_q[0] ? {1'b0, b_q} : '0);
      mul_hi    = mul_sum[W:1];
      mul_lo    = {mul_sum[0], lo_q[W-1:1]};

      div_shift = {hi_q, lo_q[W-1]};
      div_ge    = (div_shift >= {1'b0, b_q});
      div_hi    = div_ge ? W'(div_shift - {1'b0, b_q}) : div_shift[W-1:0];
      div_lo    = {lo_q[W-2:0], div_ge};

      nxt_hi_o  = div_i ? div_hi : mul_hi;
      nxt_lo_o  = div_i ? div_lo : mul_lo;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= '0;
         lo_q <= '0;
         b_q  <= '0;
      end else if (load_i) begin
         hi_q <= '0;
         lo_q <= mag_a_i;
         b_q  <= mag_b_i;
      end else if (step_i) begin
         hi_q <= nxt_hi_o;
         lo_q <= nxt_lo_o;
      end
   end

   // R3: restoring invariant, partial remainder stays below a nonzero divisor
   a_r3_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && div_i && (b_q != '0)) |-> (hi_q < b_q));

endmodule

// File: rtl/mdu_sign_fix.sv
module mdu_sign_fix #(
   parameter int W = 32
) (
   input  logic         div_i,
   input  logic         neg_a_i,
   input  logic         neg_b_i,
   input  logic [W-1:0] raw_hi_i,
   input  logic [W-1:0] raw_lo_i,
   output logic [W-1:0] hi_o,
   output logic [W-1:0] lo_o
);

   logic [2*W-1:0] prod, prod_fix;
   logic           flip;
   logic [W-1:0]   quo_fix, rem_fix;

   always_comb begin
      flip     = neg_a_i ^ neg_b_i;
      prod     = {raw_hi_i, raw_lo_i};
      prod_fix = flip ? (~prod + (2*W)'(1)) : prod;
      quo_fix  = flip ? (~raw_lo_i + W'(1)) : raw_lo_i;
      rem_fix  = neg_a_i ? (~raw_hi_i + W'(1)) : raw_hi_i;
      if (div_i) begin
         hi_o = rem_fix;
         lo_o = quo_fix;
      end else begin
         hi_o = prod_fix[2*W-1:W];
         lo_o = prod_fix[W-1:0];
      end
   end

endmodule

// File: rtl/mdu_unit.sv
module mdu_unit
   import mdu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [2:0]       op_i,
   input  logic [WIDTH-1:0] opa_i,
   input  logic [WIDTH-1:0] opb_i,
   output logic             busy_o,
   output logic             rd_valid_o,
   output logic [WIDTH-1:0] rd_data_o
);

   localparam int CNT_W = $clog2(WIDTH);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

   generate
      if (WIDTH < 4) begin : g_width_chk
         $error("mdu_unit: WIDTH must be at least 4");
      end
   endgenerate

   mdu_op_e    op_in, op_q;
   mdu_state_e state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [WIDTH-1:0] opnd_q [2];
   logic [WIDTH-1:0] mag    [2];
   logic             neg    [2];
   logic [WIDTH-1:0] hi_q, lo_q;
   logic [WIDTH-1:0] nxt_hi, nxt_lo, fix_hi, fix_lo;
   logic             accept, sgn, is_div;

   assign op_in  = mdu_op_e'(op_i);
   assign busy_o = (state_q != ST_IDLE);
   assign accept = start_i && !busy_o;
   assign sgn    = op_is_signed(op_q);
   assign is_div = op_is_div(op_q);

   for (genvar g = 0; g < 2; g++) begin : g_prep
      mdu_sign_prep #(.W(WIDTH)) u_prep (
         .signed_en_i (sgn),
         .opnd_i      (opnd_q[g]),
         .mag_o       (mag[g]),
         .neg_o       (neg[g])
      );
   end

   mdu_iter_core #(.W(WIDTH)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (state_q == ST_SETUP),
      .step_i   (state_q == ST_ITER),
      .div_i    (is_div),
      .mag_a_i  (mag[0]),
      .mag_b_i  (mag[1]),
      .nxt_hi_o (nxt_hi),
      .nxt_lo_o (nxt_lo)
   );

   mdu_sign_fix #(.W(WIDTH)) u_fix (
      .div_i    (is_div),
      .neg_a_i  (neg[0]),
      .neg_b_i  (neg[1]),
      .raw_hi_i (nxt_hi),
      .raw_lo_i (nxt_lo),
      .hi_o     (fix_hi),
      .lo_o     (fix_lo)
   );

   // control: idle -> setup (load magnitudes) -> WIDTH iteration cycles
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         op_q      <= MDU_MULTU;
         cnt_q     <= '0;
         opnd_q[0] <= '0;
         opnd_q[1] <= '0;
         hi_q      <= '0;
         lo_q      <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (accept && op_is_arith(op_in)) begin
                  op_q      <= op_in;
                  opnd_q[0] <= opa_i;
                  opnd_q[1] <= opb_i;
                  state_q   <= ST_SETUP;
               end
            end
            ST_SETUP: begin
               cnt_q   <= '0;
               state_q <= ST_ITER;
            end
            ST_ITER: begin
               cnt_q <= cnt_q + CNT_W'(1);
               if (cnt_q == LAST) begin
                  hi_q    <= fix_hi;
                  lo_q    <= fix_lo;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // read port for the move operations
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid_o <= 1'b0;
         rd_data_o  <= '0;
      end else begin
         rd_valid_o <= accept && op_is_read(op_in);
         if (accept && op_is_read(op_in)) begin
            rd_data_o <= (op_in == MDU_RDHI) ? hi_q : lo_q;
         end
      end
   end

   // R5: busy length
   a_r5_busy_falls_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ITER && cnt_q == LAST) |=> !busy_o);
   a_r5_busy_holds_mid_run: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_SETUP) || (state_q == ST_ITER && cnt_q != LAST)) |=> busy_o);
   a_r5_start_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && op_is_arith(op_in)) |=> busy_o);

   // R6: start during busy gives no read
   a_r6_busy_start_no_read: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> !rd_valid_o);

   // R7: accepted read gives a pulse one cycle later
   a_r7_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && op_is_read(op_in)) |=> rd_valid_o);
   a_r7_read_keeps_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && op_is_read(op_in)) |=> ($stable(hi_q) && $stable(lo_q)));

   // R10: reserved codes ignored
   a_r10_reserved_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && !op_is_arith(op_in) && !op_is_read(op_in))
      |=> (!busy_o && !rd_valid_o && $stable(hi_q) && $stable(lo_q)));

endmodule

// File: tb/mdu_unit_tb_top.sv
module mdu_unit_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int W          = 32;
   localparam int BUSY_LEN   = W + 1;
   localparam int WD_CYCLES  = 100000;

   typedef struct packed {
      logic [2:0]   op;
      logic [W-1:0] a;
      logic [W-1:0] b;
      logic [W-1:0] ehi;
      logic [W-1:0] elo;
      logic         chk_hi;
      logic [3:0]   req;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t TBL [NV] = '{
      '{3'd1, 32'd3,        32'd5,        32'h0000_0000, 32'h0000_000F, 1'b1, 4'd1},
      '{3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'h0000_0001, 1'b1, 4'd1},
      '{3'd1, 32'h8000_0000, 32'd2,        32'h0000_0001, 32'h0000_0000, 1'b1, 4'd1},
      '{3'd1, 32'h1234_5678, 32'd0,        32'h0000_0000, 32'h0000_0000, 1'b1, 4'd1},
      '{3'd0, 32'hFFFF_FFFF, 32'd2,        32'hFFFF_FFFF, 32'hFFFF_FFFE, 1'b1, 4'd2},
      '{3'd0, 32'hFFFF_FFFD, 32'hFFFF_FFFC, 32'h0000_0000, 32'h0000_000C, 1'b1, 4'd2},
      '{3'd0, 32'h8000_0000, 32'h8000_0000, 32'h4000_0000, 32'h0000_0000, 1'b1, 4'd2},
      '{3'd0, 32'd7,        32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFF9, 1'b1, 4'd2},
      '{3'd3, 32'd100,      32'd7,        32'h0000_0002, 32'h0000_000E, 1'b1, 4'd3},
      '{3'd3, 32'hFFFF_FFFF, 32'd16,       32'h0000_000F, 32'h0FFF_FFFF, 1'b1, 4'd3},
      '{3'd3, 32'd5,        32'd9,        32'h0000_0005, 32'h0000_0000, 1'b1, 4'd3},
      '{3'd2, 32'd20,       32'd6,        32'h0000_0002, 32'h0000_0003, 1'b1, 4'd4},
      '{3'd2, 32'hFFFF_FFF9, 32'd2,        32'h0000_0000, 32'hFFFF_FFFD, 1'b0, 4'd4},
      '{3'd2, 32'd7,        32'hFFFF_FFFE, 32'h0000_0000, 32'hFFFF_FFFD, 1'b0, 4'd4}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic [2:0]   op_i = 3'd0;
   logic [W-1:0] opa_i = '0;
   logic [W-1:0] opb_i = '0;
   logic         busy_o, rd_valid_o;
   logic [W-1:0] rd_data_o;

   int total = 0;
   int bad   = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   mdu_unit #(.WIDTH(W)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .op_i       (op_i),
      .opa_i      (opa_i),
      .opb_i      (opb_i),
      .busy_o     (busy_o),
      .rd_valid_o (rd_valid_o),
      .rd_data_o  (rd_data_o)
   );

   task automatic check(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // issue a start for one cycle; returns at the negedge after the accepting edge
   task automatic issue(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
      @(negedge clk);
      start_i = 1'b1;
      op_i    = op;
      opa_i   = a;
      opb_i   = b;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic wait_done(output int n);
      n = 0;
      while (busy_o && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic read_reg(input logic [2:0] op, output logic vld, output logic [W-1:0] val);
      issue(op, '0, '0);
      vld = rd_valid_o;
      val = rd_data_o;
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      bad++;
      total++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int           n;
      logic         vld;
      logic [W-1:0] val;
      string        rq;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R8: reset state
      check("R8", "busy after reset", W'(busy_o), '0);
      check("R8", "rd_valid after reset", W'(rd_valid_o), '0);
      read_reg(3'd4, vld, val);
      check("R8", "HI after reset", val, '0);
      read_reg(3'd5, vld, val);
      check("R8", "LO after reset", val, '0);

      // table walk: R1 R2 R3 R4, busy length R5, reads R7
      for (int i = 0; i < NV; i++) begin
         rq = $sformatf("R%0d", TBL[i].req);
         issue(TBL[i].op, TBL[i].a, TBL[i].b);
         wait_done(n);
         check("R5", "busy cycles", W'(n), W'(BUSY_LEN));
         read_reg(3'd5, vld, val);
         check("R7", "LO read valid", W'(vld), W'(1));
         check(rq, $sformatf("LO vec %0d", i), val, TBL[i].elo);
         if (TBL[i].chk_hi) begin
            read_reg(3'd4, vld, val);
            check("R7", "HI read valid", W'(vld), W'(1));
            check(rq, $sformatf("HI vec %0d", i), val, TBL[i].ehi);
         end
         @(negedge clk);
         check("R7", "read pulse one cycle", W'(rd_valid_o), '0);
      end

      // R7: repeated reads leave pair unchanged (last table result LO = -3)
      read_reg(3'd5, vld, val);
      read_reg(3'd5, vld, val);
      check("R7", "LO stable across reads", val, 32'hFFFF_FFFD);

      // R6: starts during busy are ignored
      issue(3'd3, 32'd100, 32'd7);
      @(negedge clk);
      start_i = 1'b1; op_i = 3'd4;
      @(negedge clk);
      start_i = 1'b0;
      check("R6", "no read pulse while busy", W'(rd_valid_o), '0);
      start_i = 1'b1; op_i = 3'd1; opa_i = 32'd9; opb_i = 32'd9;
      @(negedge clk);
      start_i = 1'b0;
      wait_done(n);
      check("R6", "busy length unaffected", W'(n + 3), W'(BUSY_LEN));
      read_reg(3'd5, vld, val);
      check("R6", "LO keeps first op", val, 32'd14);
      read_reg(3'd4, vld, val);
      check("R6", "HI keeps first op", val, 32'd2);

      // R10: reserved codes ignored
      issue(3'd6, 32'd1, 32'd1);
      check("R10", "code 6 no busy", W'(busy_o), '0);
      check("R10", "code 6 no read", W'(rd_valid_o), '0);
      issue(3'd7, 32'd3, 32'd3);
      check("R10", "code 7 no busy", W'(busy_o), '0);
      check("R10", "code 7 no read", W'(rd_valid_o), '0);
      read_reg(3'd5, vld, val);
      check("R10", "LO unchanged", val, 32'd14);
      read_reg(3'd4, vld, val);
      check("R10", "HI unchanged", val, 32'd2);

      // R9: divide by zero completes normally
      issue(3'd3, 32'd55, 32'd0);
      wait_done(n);
      check("R9", "divu by zero busy cycles", W'(n), W'(BUSY_LEN));
      issue(3'd2, 32'hFFFF_FF00, 32'd0);
      wait_done(n);
      check("R9", "div by zero busy cycles", W'(n), W'(BUSY_LEN));
      read_reg(3'd4, vld, val);
      check("R9", "read after div by zero", W'(vld), W'(1));

      // R5: back-to-back operation accepted right after busy falls
      issue(3'd1, 32'd6, 32'd7);
      wait_done(n);
      check("R5", "back-to-back busy cycles", W'(n), W'(BUSY_LEN));
      read_reg(3'd5, vld, val);
      check("R1", "back-to-back product", val, 32'd42);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule